// File: doc/BRIEF.md
# Configurable I/O Register Trio

This block is the register stage of one I/O cell. It holds three storage elements: one captures the value arriving from the pad, one holds the data to drive out, and one holds the output enable. All three share a single clock and a single set/reset line. Each has its own clock enable.

Two parameters shape each of the three elements independently. The first picks the storage kind: a rising-edge flip-flop, or a latch that is transparent while the clock is high. The second picks the action of the shared set/reset line on that element: synchronous set, synchronous clear, asynchronous set or asynchronous clear.

The block drives a modelled pad from the output data and enable registers. Each pad bit is either driven with its data bit or marked as high-impedance. The captured input comes back to the core side.

Top module: `ioreg_trio`

## Requirements
- R1: The three elements use the one `clk` and the one `sr` input, and each element is enabled only by its own clock enable (`ce_in`, `ce_out`, `ce_oe`).
- R2: In flip-flop mode, when set/reset is low and the element's enable is high at a rising `clk` edge, the element loads its data input, and the new value is visible after that edge.
- R3: In flip-flop mode, when set/reset and the enable are both low at a rising edge, the element keeps its value.
- R4: In latch mode, the element follows its data input while `clk` is high and its enable is high. It holds its value while `clk` is low, or while its enable is low.
- R5: In synchronous-set mode, `sr` high at a rising edge makes the element all ones, even when the enable is low. Raising `sr` between edges changes nothing until the next edge.
- R6: In synchronous-clear mode, `sr` high at a rising edge makes the element all zeros, even when the enable is low. Raising `sr` between edges changes nothing until the next edge.
- R7: In asynchronous-set mode, the element becomes all ones as soon as `sr` rises, with no clock edge needed.
- R8: In asynchronous-clear mode, the element becomes all zeros as soon as `sr` rises, with no clock edge needed.
- R9: Set/reset has priority over the enable: when `sr` and the enable are both high, the element takes its set/reset value and not its data input.
- R10: For each bit i: when `oe_q[i]` is 1, `pad_hiz[i]` is 0 and `pad_val[i]` equals `out_q[i]`. When `oe_q[i]` is 0, `pad_hiz[i]` is 1 and `pad_val[i]` is 0.
- R11: `in_q` is the value held by the input capture element, loaded from `pad_in`.
- R12: A latch in a synchronous set/reset mode applies `sr` only while `clk` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all three elements |
| sr | input | 1 | Shared set/reset, active high |
| ce_in | input | 1 | Clock enable of the input capture element |
| ce_out | input | 1 | Clock enable of the output data element |
| ce_oe | input | 1 | Clock enable of the output-enable element |
| pad_in | input | WIDTH | Value arriving from the pad |
| out_d | input | WIDTH | Data to be registered for driving out |
| oe_d | input | WIDTH | Per-bit output enable to be registered |
| in_q | output | WIDTH | Registered pad input |
| out_q | output | WIDTH | Registered output data |
| oe_q | output | WIDTH | Registered output enable |
| pad_val | output | WIDTH | Modelled pad value, 0 where not driven |
| pad_hiz | output | WIDTH | 1 where the modelled pad bit is high-impedance |

## Verification
The bench builds two instances with WIDTH of 4. The first uses the default configuration: input capture as a flip-flop with asynchronous clear, output data as a flip-flop with synchronous set, and output enable as a latch with synchronous clear. The second uses an asynchronous-set latch for input capture, an asynchronous-set flip-flop for output data, and a synchronous-clear flip-flop for output enable.

Between them the two instances cover both storage kinds and all four set/reset behaviours. They also include a latch in a synchronous mode and a latch in an asynchronous mode. Raising set/reset while the clock is low separates the asynchronous elements from the synchronous ones. Changing data and enable during the high phase shows latch transparency and latch hold.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    typedef enum logic {
        STORE_EDGE,
        STORE_LEVEL
    } store_kind_e;

    typedef enum logic [1:0] {
        SR_SYNC_SET,
        SR_SYNC_CLR,
        SR_ASYNC_SET,
        SR_ASYNC_CLR
    } sr_kind_e;

    typedef struct packed {
        logic hiz;
        logic val;
    } pad_bit_t;

    function automatic logic sr_level(input sr_kind_e k);
        return (k == SR_SYNC_SET) || (k == SR_ASYNC_SET);
    endfunction

    function automatic logic sr_is_async(input sr_kind_e k);
        return (k == SR_ASYNC_SET) || (k == SR_ASYNC_CLR);
    endfunction

    function automatic pad_bit_t pad_resolve(input logic en, input logic d);
        pad_bit_t p;
        p.hiz = ~en;
        p.val = en & d;
        return p;
    endfunction

endpackage

// File: rtl/ioc_store.sv
module ioc_store
    import ioc_pkg::*;
#(
    parameter int          WIDTH = 4,
    parameter store_kind_e KIND  = STORE_EDGE,
    parameter sr_kind_e    SR    = SR_SYNC_CLR
) (
    input  logic             clk,
    input  logic             sr,
    input  logic             ce,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam logic             SR_BIT = sr_level(SR);
    localparam logic [WIDTH-1:0] SR_VAL = {WIDTH{SR_BIT}};
    localparam bit               ASYNC  = sr_is_async(SR);

    generate
        if (KIND == STORE_EDGE && ASYNC) begin : g_ff_async
            always_ff @(posedge clk or posedge sr) begin
                if (sr)      q <= SR_VAL;
                else if (ce) q <= d;
            end
        end else if (KIND == STORE_EDGE) begin : g_ff_sync
            always_ff @(posedge clk) begin
                if (sr)      q <= SR_VAL;
                else if (ce) q <= d;
            end
        end else if (ASYNC) begin : g_lat_async
            always_latch begin
                if (sr)             q <= SR_VAL;
                else if (clk && ce) q <= d;
            end
        end else begin : g_lat_sync
            always_latch begin
                if (clk && sr)      q <= SR_VAL;
                else if (clk && ce) q <= d;
            end
        end
    endgenerate

    // Checks become active once set/reset has been seen at an edge.
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (sr) armed <= 1'b1;
    end

    generate
        if (KIND == STORE_EDGE && !ASYNC) begin : g_chk_ff_sync
            p_sync_sr_r5_r6: assert property (@(posedge clk) disable iff (!armed)
                sr |=> (q == SR_VAL));
            p_capture_r2: assert property (@(posedge clk) disable iff (!armed)
                (!sr && ce) |=> (q == $past(d)));
            p_hold_r3: assert property (@(posedge clk) disable iff (!armed)
                (!sr && !ce) |=> (q == $past(q)));
        end
        if (ASYNC) begin : g_chk_async
            p_async_sr_r7_r8: assert property (@(posedge clk) disable iff (!armed)
                sr |-> (q == SR_VAL));
        end
        if (KIND == STORE_LEVEL) begin : g_chk_latch
            p_latch_pass_r4: assert property (@(negedge clk) disable iff (!armed)
                (!sr && ce) |-> (q == d));
        end
    endgenerate

endmodule

// File: rtl/ioc_pad.sv
module ioc_pad
    import ioc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] drv,
    input  logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] hiz
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            pad_bit_t b;
            assign b      = pad_resolve(en[i], drv[i]);
            assign val[i] = b.val;
            assign hiz[i] = b.hiz;
        end
    endgenerate

endmodule

// File: rtl/ioreg_trio.sv
module ioreg_trio
    import ioc_pkg::*;
#(
    parameter int          WIDTH    = 4,
    parameter store_kind_e IN_KIND  = STORE_EDGE,
    parameter sr_kind_e    IN_SR    = SR_ASYNC_CLR,
    parameter store_kind_e OUT_KIND = STORE_EDGE,
    parameter sr_kind_e    OUT_SR   = SR_SYNC_SET,
    parameter store_kind_e OE_KIND  = STORE_LEVEL,
    parameter sr_kind_e    OE_SR    = SR_SYNC_CLR
) (
    input  logic             clk,
    input  logic             sr,
    input  logic             ce_in,
    input  logic             ce_out,
    input  logic             ce_oe,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] out_d,
    input  logic [WIDTH-1:0] oe_d,
    output logic [WIDTH-1:0] in_q,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] oe_q,
    output logic [WIDTH-1:0] pad_val,
    output logic [WIDTH-1:0] pad_hiz
);

    // R1: one clock and one set/reset, a separate enable for each element.
    ioc_store #(.WIDTH(WIDTH), .KIND(IN_KIND), .SR(IN_SR)) u_in (
        .clk(clk), .sr(sr), .ce(ce_in), .d(pad_in), .q(in_q)   // R11
    );

    ioc_store #(.WIDTH(WIDTH), .KIND(OUT_KIND), .SR(OUT_SR)) u_out (
        .clk(clk), .sr(sr), .ce(ce_out), .d(out_d), .q(out_q)
    );

    ioc_store #(.WIDTH(WIDTH), .KIND(OE_KIND), .SR(OE_SR)) u_oe (
        .clk(clk), .sr(sr), .ce(ce_oe), .d(oe_d), .q(oe_q)
    );

    ioc_pad #(.WIDTH(WIDTH)) u_pad (
        .drv(out_q), .en(oe_q), .val(pad_val), .hiz(pad_hiz)
    );

endmodule

// File: tb/sim_ioreg_trio.sv
module sim_ioreg_trio;
    import ioc_pkg::*;

    localparam int W = 4;

    logic clk = 1'b0;
    logic sr = 1'b1;
    logic ce_in = 1'b0, ce_out = 1'b0, ce_oe = 1'b0;
    logic [W-1:0] pad_in = '0, out_d = '0, oe_d = '0;
    logic [W-1:0] in0, out0, oe0, pv0, ph0;
    logic [W-1:0] in1, out1, oe1, pv1, ph1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ioreg_trio #(.WIDTH(W)) u0 (
        .clk(clk), .sr(sr), .ce_in(ce_in), .ce_out(ce_out), .ce_oe(ce_oe),
        .pad_in(pad_in), .out_d(out_d), .oe_d(oe_d),
        .in_q(in0), .out_q(out0), .oe_q(oe0), .pad_val(pv0), .pad_hiz(ph0)
    );

    ioreg_trio #(.WIDTH(W),
        .IN_KIND(STORE_LEVEL), .IN_SR(SR_ASYNC_SET),
        .OUT_KIND(STORE_EDGE), .OUT_SR(SR_ASYNC_SET),
        .OE_KIND(STORE_EDGE),  .OE_SR(SR_SYNC_CLR)) u1 (
        .clk(clk), .sr(sr), .ce_in(ce_in), .ce_out(ce_out), .ce_oe(ce_oe),
        .pad_in(pad_in), .out_d(out_d), .oe_d(oe_d),
        .in_q(in1), .out_q(out1), .oe_q(oe1), .pad_val(pv1), .pad_hiz(ph1)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Stimulus: {sr, ce_in, ce_out, ce_oe, pad_in, out_d, oe_d}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        16'h7A5C, 16'h03C1, 16'h49FF, 16'h2E12, 16'h1777, 16'hF123,
        16'h7F0F, 16'h8AAA, 16'h75A3, 16'h0000, 16'h36C9, 16'h50F5
    };

    logic [W-1:0] m_in0, m_out0, m_oe0, m_in1, m_out1, m_oe1;

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state, checked in the high phase after the first edge
        @(posedge clk); #5;
        chk("R8 reset u0 in", in0, 4'h0);
        chk("R5 reset u0 out", out0, 4'hF);
        chk("R12 reset u0 oe", oe0, 4'h0);
        chk("R10 reset u0 hiz", ph0, 4'hF);
        chk("R10 reset u0 val", pv0, 4'h0);
        chk("R7 reset u1 in", in1, 4'hF);
        chk("R7 reset u1 out", out1, 4'hF);
        chk("R6 reset u1 oe", oe1, 4'h0);
        m_in0 = 4'h0; m_out0 = 4'hF; m_oe0 = 4'h0;
        m_in1 = 4'hF; m_out1 = 4'hF; m_oe1 = 4'h0;

        // Table walk: drive on the falling edge, check mid high phase.
        // Every element reduces here to: sr ? set/reset value : ce ? d : held.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {sr, ce_in, ce_out, ce_oe, pad_in, out_d, oe_d} = VEC[v];
            @(posedge clk); #5;
            m_in0  = sr ? 4'h0 : (ce_in  ? pad_in : m_in0);
            m_out0 = sr ? 4'hF : (ce_out ? out_d  : m_out0);
            m_oe0  = sr ? 4'h0 : (ce_oe  ? oe_d   : m_oe0);
            m_in1  = sr ? 4'hF : (ce_in  ? pad_in : m_in1);
            m_out1 = sr ? 4'hF : (ce_out ? out_d  : m_out1);
            m_oe1  = sr ? 4'h0 : (ce_oe  ? oe_d   : m_oe1);
            chk("R2/R3/R9/R11 u0 in", in0, m_in0);
            chk("R2/R3/R9 u0 out", out0, m_out0);
            chk("R4/R9 u0 oe", oe0, m_oe0);
            chk("R4/R9/R11 u1 in", in1, m_in1);
            chk("R2/R3/R9 u1 out", out1, m_out1);
            chk("R2/R3/R9 u1 oe", oe1, m_oe1);
            chk("R10 u0 val", pv0, m_out0 & m_oe0);
            chk("R10 u0 hiz", ph0, ~m_oe0);
        end

        // R7 R8 R5 R6 R12: raise sr in the low phase
        @(negedge clk);
        sr = 1'b0; ce_in = 1'b1; ce_out = 1'b1; ce_oe = 1'b1;
        pad_in = 4'h6; out_d = 4'h9; oe_d = 4'hF;
        @(posedge clk); #5;
        chk("R2 u0 out load", out0, 4'h9);
        @(negedge clk);
        sr = 1'b1; ce_in = 1'b0; ce_out = 1'b0; ce_oe = 1'b0;
        pad_in = 4'h0; out_d = 4'h0; oe_d = 4'h0;
        #2;
        chk("R8 u0 in cleared at once", in0, 4'h0);
        chk("R5 u0 out waits for edge", out0, 4'h9);
        chk("R12 u0 oe latch waits for high", oe0, 4'hF);
        chk("R7 u1 in set at once", in1, 4'hF);
        chk("R7 u1 out set at once", out1, 4'hF);
        chk("R6 u1 oe waits for edge", oe1, 4'hF);
        @(posedge clk); #5;
        chk("R5 u0 out set at edge", out0, 4'hF);
        chk("R12 u0 oe cleared in high", oe0, 4'h0);
        chk("R6 u1 oe cleared at edge", oe1, 4'h0);

        // R4: latch hold in low phase, transparency and enable-low hold in high
        @(negedge clk);
        sr = 1'b0; ce_oe = 1'b1; oe_d = 4'h5; ce_in = 1'b1; pad_in = 4'h3;
        #2;
        chk("R4 u0 oe holds while clk low", oe0, 4'h0);
        chk("R4 u1 in holds while clk low", in1, 4'hF);
        @(posedge clk); #2;
        chk("R4 u0 oe passes in high", oe0, 4'h5);
        chk("R4 u1 in passes in high", in1, 4'h3);
        oe_d = 4'hA; pad_in = 4'hC; #1;
        chk("R4 u0 oe follows d", oe0, 4'hA);
        chk("R4 u1 in follows d", in1, 4'hC);
        ce_oe = 1'b0; ce_in = 1'b0; oe_d = 4'h6; pad_in = 4'h1; #1;
        chk("R4 u0 oe holds with ce low", oe0, 4'hA);
        chk("R4 u1 in holds with ce low", in1, 4'hC);
        chk("R3 u0 out held", out0, 4'hF);

        // R10: per-bit pad drive
        @(negedge clk);
        ce_out = 1'b1; ce_oe = 1'b1; out_d = 4'h3; oe_d = 4'h5;
        @(posedge clk); #5;
        chk("R10 u0 pad val", pv0, 4'h1);
        chk("R10 u0 pad hiz", ph0, 4'hA);
        chk("R10 u1 pad val", pv1, 4'h1);
        chk("R10 u1 pad hiz", ph1, 4'hA);
        @(negedge clk);
        oe_d = 4'h0;
        @(posedge clk); #5;
        chk("R10 u0 all hiz", ph0, 4'hF);
        chk("R10 u0 undriven val", pv0, 4'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule